// File: doc/BRIEF.md
# Output Bank Post-Divider

This block turns a fast source clock into a slower output bank clock. A programmable integer sets the ratio, and the counter stage counts that value plus two. The counter's terminal count drives a toggle stage. Because the toggle is always present, the output has a 50 % duty cycle and its full period is twice the counter length. In all, one output period lasts 2*(Q+2) source cycles.

Two controls decide whether a clock leaves the block. The divider-run control stops the whole divider: the counter and toggle are held cleared, and no clock is produced. The output-enable control keeps the divider running but holds the pin at its idle level. An invert control flips the polarity of the pin, and this also makes the idle level high.

A new ratio is taken in only at the end of an output period, which is the high-to-low transition of the internal toggle. This keeps every half period whole.

Top module: `pdiv_out_bank`

## Requirements
- R1: While reset is asserted, clk_out is low, the counter is cleared and the toggle stage is low.
- R2: While running and enabled, every high half and every low half of clk_out lasts exactly div_q+2 source cycles, so the period is 2*(div_q+2) cycles (checked for div_q = 0, 5, 1, 3).
- R3: div_q is a 10-bit unsigned value. The maximum, 1023, gives half periods of 1025 source cycles.
- R4: If div_q changes during a low half, the current low half and the high half that follows both keep the old ratio. The new ratio applies from the next low half.
- R5: If div_q changes during a high half, that high half finishes with the old ratio. The new ratio applies from the very next low half.
- R6: While div_on is low, clk_out stays at its idle level, and the counter and toggle are cleared. The ratio register follows div_q each cycle in this state. After div_on returns high, the first transition away from the idle level appears at the sample div_q+2 cycles later.
- R7: While out_en is low, clk_out stays at its idle level from the next source edge, and the divider keeps counting. Once out_en returns high, whole half periods of div_q+2 cycles resume.
- R8: When out_inv is high, the idle level is high and clk_out is the complement of the toggle stage. Half-period lengths do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_q | input | 10 | Ratio value Q; each half period lasts Q+2 cycles |
| div_on | input | 1 | Divider run control; low stops and clears the divider |
| out_en | input | 1 | Output enable; low holds the pin at its idle level |
| out_inv | input | 1 | Output polarity inversion |
| clk_out | output | 1 | Divided output bank clock |

## Verification
The output register updates on the same source edge as the toggle stage. A change on out_en or out_inv therefore shows on clk_out one edge after it is applied. After div_on rises, the first transition is seen at the sample div_q+2 edges later. A new div_q first shapes the low half that begins at the next toggle fall.

The bench samples clk_out on the falling source edge and measures each run between transitions. It compares every run with a queue of expected lengths that the driver builds from the ratio value and the half of the period in which the ratio was written. After any change that can cut a run short, the bench discards the two runs around that change. Restart latency and the idle levels are counted sample by sample.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;

    localparam int unsigned PDIV_QW_DEFAULT = 10;

    typedef struct packed {
        logic tog;
    } tog_st_t;

    typedef struct packed {
        logic lvl;
    } gate_st_t;

endpackage

// File: rtl/pdiv_count.sv
`timescale 1ns/1ps
module pdiv_count #(
    parameter int unsigned QW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [QW-1:0] div_q,
    input  logic          tog_q,
    output logic          term
);
    localparam int unsigned CW = QW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [QW-1:0] ratio;
    } cnt_st_t;

    cnt_st_t       st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = {1'b0, st_q.ratio} + CW'(1);
        term = run && (st_q.cnt == lim);
        if (!run) begin
            st_d.cnt   = '0;
            st_d.ratio = div_q;
        end else if (term) begin
            st_d.cnt = '0;
            if (tog_q) begin
                st_d.ratio = div_q;
            end
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= lim);

    a_r6_off_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.cnt == '0);

    a_r4_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(term && tog_q)) |=> $stable(st_q.ratio));

endmodule

// File: rtl/pdiv_toggle.sv
`timescale 1ns/1ps
module pdiv_toggle
    import pdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic term,
    output logic tog_q,
    output logic tog_nx
);
    tog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.tog = 1'b0;
        end else if (term) begin
            st_d.tog = ~st_q.tog;
        end
        tog_nx = st_d.tog;
        tog_q  = st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r2_toggle_only_on_term: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !term) |=> $stable(st_q.tog));

    a_r6_off_clears_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !st_q.tog);

endmodule

// File: rtl/pdiv_gate.sv
`timescale 1ns/1ps
module pdiv_gate
    import pdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic out_en,
    input  logic out_inv,
    input  logic tog_nx,
    output logic clk_o
);
    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run && out_en) begin
            st_d.lvl = tog_nx ^ out_inv;
        end else begin
            st_d.lvl = out_inv;
        end
        clk_o = st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r7_idle_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en || !run) |=> clk_o == $past(out_inv));

endmodule

// File: rtl/pdiv_out_bank.sv
`timescale 1ns/1ps
module pdiv_out_bank
    import pdiv_pkg::*;
#(
    parameter int unsigned QW = PDIV_QW_DEFAULT
) (
    input  logic          clk_src,
    input  logic          rst_n,
    input  logic [QW-1:0] div_q,
    input  logic          div_on,
    input  logic          out_en,
    input  logic          out_inv,
    output logic          clk_out
);
    logic term;
    logic tog_q;
    logic tog_nx;

    pdiv_count #(.QW(QW)) u_count (
        .clk   (clk_src),
        .rst_n (rst_n),
        .run   (div_on),
        .div_q (div_q),
        .tog_q (tog_q),
        .term  (term)
    );

    pdiv_toggle u_toggle (
        .clk    (clk_src),
        .rst_n  (rst_n),
        .run    (div_on),
        .term   (term),
        .tog_q  (tog_q),
        .tog_nx (tog_nx)
    );

    pdiv_gate u_gate (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .run     (div_on),
        .out_en  (out_en),
        .out_inv (out_inv),
        .tog_nx  (tog_nx),
        .clk_o   (clk_out)
    );

    a_r8_follows_toggle: assert property (@(posedge clk_src) disable iff (!rst_n)
        (div_on && out_en && $stable(out_inv) && $past(div_on) && $past(out_en))
            |-> clk_out == (tog_q ^ out_inv));

endmodule

// File: tb/pdiv_out_bank_tb.sv
`timescale 1ns/1ps
module pdiv_out_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] div_q = '0;
    logic       div_on = 1'b0;
    logic       out_en = 1'b0;
    logic       out_inv = 1'b0;
    logic       clk_out;

    int    checks = 0;
    int    errors = 0;
    int    exp_q[$];
    string tag_q[$];
    int    skip = 2;
    int    run_len = 0;
    logic  prev = 1'b0;

    pdiv_out_bank u_dut (
        .clk_src (clk_src_w),
        .rst_n   (rst_n),
        .div_q   (div_q),
        .div_on  (div_on),
        .out_en  (out_en),
        .out_inv (out_inv),
        .clk_out (clk_out)
    );

    wire clk_src_w;
    assign clk_src_w = clk;

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (clk_out !== prev) begin
                if (skip > 0) begin
                    skip--;
                end else if (exp_q.size() > 0) begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(run_len == e, t, run_len, e);
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            prev = clk_out;
        end
    end

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic push(input int n, input int len, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(len);
            tag_q.push_back(tag);
        end
    endtask

    task automatic flush();
        exp_q.delete();
        tag_q.delete();
        skip = 2;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic wait_edge(input logic lvl);
        logic p;
        p = clk_out;
        forever begin
            @(negedge clk);
            if (clk_out == lvl && p != lvl) break;
            p = clk_out;
        end
        #2;
    endtask

    task automatic restart_count(input logic idle, input int exp, input string tag);
        int k;
        k = 0;
        div_on = 1'b1;
        do begin
            @(negedge clk);
            k++;
        end while (clk_out == idle && k < 3000);
        check(k == exp, tag, k, exp);
    endtask

    task automatic hold_check(input int n, input logic lvl, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_out !== lvl) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset level
        repeat (3) @(negedge clk);
        check(clk_out === 1'b0, "R1 reset level", int'(clk_out), 0);
        #2 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(clk_out === 1'b0, "R6 idle after reset", int'(clk_out), 0);

        // R6 restart latency and R2 with Q=0
        #2 out_en = 1'b1;
        restart_count(1'b0, 2, "R6 restart Q=0");
        #2 flush();
        push(6, 2, "R2 half period Q=0");
        drain();

        // R2 with Q=5 after a stop, R6 restart latency
        settle(); div_on = 1'b0;
        settle(); div_q = 10'd5;
        settle();
        restart_count(1'b0, 7, "R6 restart Q=5");
        #2 flush();
        push(6, 7, "R2 half period Q=5");
        drain();

        // R4: ratio written during a low half
        wait_edge(1'b0);
        div_q = 10'd1;
        push(2, 7, "R4 old ratio kept");
        push(4, 3, "R4 new ratio Q=1");
        drain();

        // R5: ratio written during a high half
        wait_edge(1'b1);
        div_q = 10'd3;
        push(1, 3, "R5 high half old ratio");
        push(4, 5, "R5 new ratio Q=3");
        drain();

        // R7: output enable gating while the toggle is high
        wait_edge(1'b1);
        out_en = 1'b0;
        flush();
        @(negedge clk);
        hold_check(20, 1'b0, "R7 idle while disabled");
        #2 out_en = 1'b1;
        flush();
        push(4, 5, "R7 resumed half period");
        drain();

        // R8: inversion
        settle();
        out_inv = 1'b1;
        flush();
        push(4, 5, "R8 inverted half period");
        drain();
        settle(); div_on = 1'b0;
        @(negedge clk);
        hold_check(10, 1'b1, "R8 idle high when inverted");
        #2 restart_count(1'b1, 5, "R6 restart inverted Q=3");

        // R3: maximum ratio, written during a high half
        settle();
        out_inv = 1'b0;
        flush();
        push(4, 5, "R2 half period after polarity change");
        drain();
        wait_edge(1'b1);
        div_q = 10'd1023;
        push(1, 5, "R5 high half before max ratio");
        push(3, 1025, "R3 half period Q=1023");
        drain();

        // R6: stop mid-run
        settle(); div_on = 1'b0;
        @(negedge clk);
        hold_check(10, 1'b0, "R6 idle while stopped");

        summary();
        $finish;
    end
endmodule